// File: doc/BRIEF.md
# Clock Output Mode Selector with Test Divider

This block sits between the gated synthesized clocks of a clock generator and its output pins. It chooses what every output group drives. The choice comes from a 2-bit operating-mode field in the low bits of configuration register 0. In normal operation it passes the gated clocks straight through. In the high-impedance mode it turns every output driver off. In test mode it drops the synthesized clocks and drives a fixed division of a test clock that is applied on the crystal input. Two further bits of the same register pick the divisor used by the two fixed-frequency outputs in test mode. Spread-spectrum modulation is not modelled, and its code behaves exactly like normal operation.

All logic runs on one fast sampling clock. The crystal-input waveform and the gated clocks are treated as sampled level signals. The block has its own divider chain, built from edge detection on the sampled test clock. The divider is held cleared outside test mode, so the half-rate and quarter-rate outputs rise together on the first test-clock edge. A requested mode change waits for a cycle in which the outputs of the current mode and the outputs of the requested mode are both all low. Switching therefore never cuts a pulse short.

Top module: `oms_top`

## Requirements
- R1: After reset the active mode is normal operation, the driver enable is 1 and the test divider is cleared.
- R2: Mode field cfg_i[1:0] = 00 selects normal operation: every output equals its gated-clock input, and the driver enable is 1.
- R3: Mode field 01 selects high impedance: the driver enable is 0 and every output data bit is 0.
- R4: Mode field 10 (spread spectrum) behaves exactly as normal operation.
- R5: Mode field 11 selects test mode. The CPU and SDRAM outputs drive the test clock divided by 2, which goes high on the 1st, 3rd, 5th ... rising edge of the test clock after entry.
- R6: In test mode the PCI and free-running PCI outputs drive the test clock divided by 4. This output is high from the 1st rising edge after entry until the 3rd, then repeats with a period of 4 rising edges.
- R7: In test mode the REF and IOAPIC outputs drive the test clock undivided, delayed by one sampling cycle.
- R8: In test mode fix_o[0] is selected by cfg_i[2] and fix_o[1] by cfg_i[3]. A select bit of 1 (48 MHz) gives divide by 2, and a select bit of 0 (24 MHz) gives divide by 4.
- R9: A change of the mode field takes effect at a clock edge only if the outputs under the current mode and under the requested mode are both all zero before that edge. Until then the previous mode is held.
- R10: The test divider is held at zero outside test mode. On the first test-clock rise after entry, the divide-by-2 and divide-by-4 outputs rise in the same cycle.
- R11: Outside test mode, cfg_i[3:2] has no effect on the fixed outputs, which follow fix_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 4 | Register 0 bits [3:0]: [1:0] mode, [2] fix0 select, [3] fix1 select |
| xin_i | input | 1 | Sampled test clock from the crystal input |
| cpu_i | input | NCPU | Gated CPU clocks |
| pci_i | input | NPCI | Gated PCI clocks |
| pcif_i | input | 1 | Free-running PCI clock |
| sdram_i | input | NSDR | Gated SDRAM clocks |
| ref_i | input | NREF | Gated reference clocks |
| apic_i | input | 1 | Gated IOAPIC clock |
| fix_i | input | 2 | Gated 48/24 MHz clocks |
| cpu_o | output | NCPU | CPU outputs |
| pci_o | output | NPCI | PCI outputs |
| pcif_o | output | 1 | Free-running PCI output |
| sdram_o | output | NSDR | SDRAM outputs |
| ref_o | output | NREF | Reference outputs |
| apic_o | output | 1 | IOAPIC output |
| fix_o | output | 2 | Fixed-frequency outputs |
| drv_en_o | output | 1 | Output driver enable, 0 = high impedance |

## Verification
The assertions check on every cycle that a mode change only lands after a quiet cycle. They also check that the high-impedance mode drives nothing, that the divide-by-2 tap moves only after a sampled test-clock rise, that the quarter tap moves only as the half tap rises, that the divider stays cleared while idle, and that the undivided test output tracks the input one cycle late. The bench scenarios show the rest: the exact divide sequences after entry, the per-output select bits, spread spectrum falling back to normal, a mode request held back while clocks are high, and the select bits having no effect outside test mode.

// File: rtl/oms_pkg.sv
package oms_pkg;

   typedef enum logic [1:0] {
      OM_NORM = 2'b00,
      OM_HIZ  = 2'b01,
      OM_TEST = 2'b11
   } om_e;

   // spread spectrum (10) is not modelled and falls back to normal
   function automatic om_e decode_mode(input logic [1:0] field);
      case (field)
         2'b01:   decode_mode = OM_HIZ;
         2'b11:   decode_mode = OM_TEST;
         default: decode_mode = OM_NORM;
      endcase
   endfunction

endpackage

// File: rtl/oms_tdiv.sv
module oms_tdiv #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              xin_i,
   output logic [STAGES:0]   tap_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("oms_tdiv: STAGES must be at least 1");
      end
   endgenerate

   logic              xin_q;
   logic [STAGES-1:0] cnt_q;
   logic [STAGES-1:0] cnt_m1;
   logic              rise;

   assign rise   = xin_i & ~xin_q;
   assign cnt_m1 = cnt_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xin_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         xin_q <= xin_i;
         if (!en)
            cnt_q <= '0;
         else if (rise)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tap_o[0] = xin_q;

   // tap k is high for the first half of each 2^k-edge period after entry
   generate
      for (genvar k = 1; k <= STAGES; k++) begin : g_tap
         assign tap_o[k] = ~cnt_m1[k-1];
      end
   endgenerate

   assert_half_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && tap_o[1] != $past(tap_o[1])) |-> $past(xin_i && !xin_q));

   generate
      if (STAGES >= 2) begin : g_quarter_chk
         assert_quarter_with_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en && $past(en) && tap_o[2] != $past(tap_o[2])) |-> tap_o[1]);
      end
   endgenerate

   assert_idle_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (tap_o[STAGES:1] == '0));

endmodule

// File: rtl/oms_mode_reg.sv
module oms_mode_reg
   import oms_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  om_e  req_i,
   input  logic quiet_i,
   output om_e  mode_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_o <= OM_NORM;
      else if (quiet_i)
         mode_o <= req_i;
   end

   assert_switch_when_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> $past(quiet_i));

   assert_hold_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !quiet_i |=> $stable(mode_o));

endmodule

// File: rtl/oms_top.sv
module oms_top
   import oms_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int NPCI = 6,
   parameter int NSDR = 8,
   parameter int NREF = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      cfg_i,
   input  logic            xin_i,
   input  logic [NCPU-1:0] cpu_i,
   input  logic [NPCI-1:0] pci_i,
   input  logic            pcif_i,
   input  logic [NSDR-1:0] sdram_i,
   input  logic [NREF-1:0] ref_i,
   input  logic            apic_i,
   input  logic [1:0]      fix_i,
   output logic [NCPU-1:0] cpu_o,
   output logic [NPCI-1:0] pci_o,
   output logic            pcif_o,
   output logic [NSDR-1:0] sdram_o,
   output logic [NREF-1:0] ref_o,
   output logic            apic_o,
   output logic [1:0]      fix_o,
   output logic            drv_en_o
);

   localparam int DIV_STAGES = 2;
   localparam int W = NCPU + NPCI + 1 + NSDR + NREF + 1 + 2;

   generate
      if (NCPU < 1 || NPCI < 1 || NSDR < 1 || NREF < 1) begin : g_bad_width
         $error("oms_top: every output group needs at least one pin");
      end
   endgenerate

   om_e                  mode_q;
   om_e                  mode_req;
   logic [DIV_STAGES:0]  taps;
   logic                 t1, t2, t4;
   logic [W-1:0]         w_norm, w_test, w_cur, w_req;
   logic                 quiet;

   function automatic logic [W-1:0] pick(input om_e m, input logic [W-1:0] n,
                                         input logic [W-1:0] t);
      case (m)
         OM_HIZ:  pick = '0;
         OM_TEST: pick = t;
         default: pick = n;
      endcase
   endfunction

   assign mode_req = decode_mode(cfg_i[1:0]);

   oms_tdiv #(.STAGES(DIV_STAGES)) tdiv_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mode_q == OM_TEST),
      .xin_i (xin_i),
      .tap_o (taps)
   );

   assign t1 = taps[0];
   assign t2 = taps[1];
   assign t4 = taps[2];

   assign w_norm = {cpu_i, pci_i, pcif_i, sdram_i, ref_i, apic_i, fix_i};
   assign w_test = {{NCPU{t2}}, {NPCI{t4}}, t4, {NSDR{t2}}, {NREF{t1}}, t1,
                    (cfg_i[3] ? t2 : t4), (cfg_i[2] ? t2 : t4)};

   assign w_cur = pick(mode_q,   w_norm, w_test);
   assign w_req = pick(mode_req, w_norm, w_test);
   assign quiet = (w_cur == '0) && (w_req == '0);

   oms_mode_reg mreg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (mode_req),
      .quiet_i (quiet),
      .mode_o  (mode_q)
   );

   assign {cpu_o, pci_o, pcif_o, sdram_o, ref_o, apic_o, fix_o} = w_cur;
   assign drv_en_o = (mode_q != OM_HIZ);

   assert_hiz_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OM_HIZ) |-> (!drv_en_o && cpu_o == '0 && pci_o == '0 && !pcif_o
                              && sdram_o == '0 && ref_o == '0 && !apic_o && fix_o == '0));

   assert_ref_follows_xin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OM_TEST && $past(mode_q) == OM_TEST) |-> (ref_o == {NREF{$past(xin_i)}}));

endmodule

// File: tb/oms_top_tb_top.sv
module oms_top_tb_top;

   localparam int NCPU = 4;
   localparam int NPCI = 6;
   localparam int NSDR = 8;
   localparam int NREF = 2;
   localparam int W = NCPU + NPCI + 1 + NSDR + NREF + 1 + 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      cfg = 4'b1100;
   logic            xin = 1'b0;
   logic            phase = 1'b0;
   logic [W-1:0]    mask = '1;
   logic [W-1:0]    nin;

   logic [NCPU-1:0] cpu_i;
   logic [NPCI-1:0] pci_i;
   logic            pcif_i;
   logic [NSDR-1:0] sdram_i;
   logic [NREF-1:0] ref_i;
   logic            apic_i;
   logic [1:0]      fix_i;
   logic [NCPU-1:0] cpu_o;
   logic [NPCI-1:0] pci_o;
   logic            pcif_o;
   logic [NSDR-1:0] sdram_o;
   logic [NREF-1:0] ref_o;
   logic            apic_o;
   logic [1:0]      fix_o;
   logic            drv_en_o;
   logic [W-1:0]    got;

   int tests = 0;
   int fails = 0;

   // reference model state
   int   mode_m = 0;
   int   cnt_m = 0;
   logic xq_m = 1'b0;

   always #2.5 clk = ~clk;

   assign nin = mask & {W{phase}};
   assign {cpu_i, pci_i, pcif_i, sdram_i, ref_i, apic_i, fix_i} = nin;
   assign got = {cpu_o, pci_o, pcif_o, sdram_o, ref_o, apic_o, fix_o};

   oms_top #(.NCPU(NCPU), .NPCI(NPCI), .NSDR(NSDR), .NREF(NREF)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .xin_i(xin),
      .cpu_i(cpu_i), .pci_i(pci_i), .pcif_i(pcif_i), .sdram_i(sdram_i),
      .ref_i(ref_i), .apic_i(apic_i), .fix_i(fix_i),
      .cpu_o(cpu_o), .pci_o(pci_o), .pcif_o(pcif_o), .sdram_o(sdram_o),
      .ref_o(ref_o), .apic_o(apic_o), .fix_o(fix_o), .drv_en_o(drv_en_o)
   );

   function automatic int dec(input logic [1:0] f);
      if (f == 2'b01) return 1;
      if (f == 2'b11) return 3;
      return 0;
   endfunction

   function automatic logic [W-1:0] word_for(input int m);
      logic d1, d2, d4, f0, f1;
      d1 = xq_m;
      d2 = (cnt_m % 2) == 1;
      d4 = (cnt_m == 1) || (cnt_m == 2);
      f0 = cfg[2] ? d2 : d4;
      f1 = cfg[3] ? d2 : d4;
      if (m == 1) return '0;
      if (m == 3) return {{NCPU{d2}}, {NPCI{d4}}, d4, {NSDR{d2}}, {NREF{d1}}, d1, f1, f0};
      return nin;
   endfunction

   // one sampling cycle: model the edge, then return at the next falling edge
   task automatic step();
      int old;
      int req;
      @(posedge clk);
      old = mode_m;
      req = dec(cfg[1:0]);
      if (req != old && word_for(old) == '0 && word_for(req) == '0) mode_m = req;
      if (old != 3) cnt_m = 0;
      else if (xin && !xq_m) cnt_m = (cnt_m + 1) % 4;
      xq_m = xin;
      @(negedge clk);
   endtask

   task automatic check(input string tag);
      logic [W-1:0] exp_w;
      logic         exp_en;
      exp_w  = word_for(mode_m);
      exp_en = (mode_m != 1);
      tests++;
      if (got !== exp_w || drv_en_o !== exp_en) begin
         fails++;
         $display("FAIL %s: got word=%h en=%b, expected word=%h en=%b",
                  tag, got, drv_en_o, exp_w, exp_en);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp_v);
      tests++;
      if (act !== exp_v) begin
         fails++;
         $display("FAIL %s: got %b, expected %b", tag, act, exp_v);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0c1c));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      phase = 1'b1;
      #0.1;
      // R1: reset state passes gated clocks, drivers on
      check("R1");
      check_bit("R1", drv_en_o, 1'b1);

      // R2: normal pass-through under several masks
      for (int i = 0; i < 6; i++) begin
         mask = W'($urandom());
         phase = i[0];
         step();
         check("R2");
      end

      // R11: select bits ignored outside test mode
      mask = '1; phase = 1'b1; cfg = 4'b0000;
      step();
      check_bit("R11", fix_o[0], 1'b1);
      check_bit("R11", fix_o[1], 1'b1);

      // R9: high-impedance request held while clocks are high
      cfg = 4'b0001;
      step();
      check_bit("R9", drv_en_o, 1'b1);
      check("R9");
      phase = 1'b0;
      step();
      phase = 1'b1;
      step();
      // R3: all outputs low, drivers off
      check("R3");
      check_bit("R3", drv_en_o, 1'b0);

      // R4: spread code behaves as normal
      cfg = 4'b0010; phase = 1'b0;
      step();
      phase = 1'b1;
      step();
      check("R4");
      check_bit("R4", cpu_o[0], 1'b1);

      // enter test: fix1 /2 (cfg[3]=1), fix0 /4 (cfg[2]=0)
      phase = 1'b0; xin = 1'b0; cfg = 4'b1011;
      step();
      check("R5");
      xin = 1'b1;
      step();
      // R10: first rise makes /2 and /4 high together
      check_bit("R10", cpu_o[0], 1'b1);
      check_bit("R10", pci_o[0], 1'b1);
      for (int i = 0; i < 12; i++) begin
         xin = ~xin;
         step();
         case (i % 4)
            0: check("R5");
            1: check("R6");
            2: check("R7");
            default: check("R8");
         endcase
      end
      cfg = 4'b0111;
      for (int i = 0; i < 8; i++) begin
         xin = ~xin;
         step();
         check("R8");
      end

      // constrained random with coherent clock phase
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(1, 0) == 1) phase = ~phase;
         if ($urandom_range(1, 0) == 1) xin = ~xin;
         if ($urandom_range(15, 0) == 0) mask = W'($urandom());
         if ($urandom_range(31, 0) == 0) cfg = 4'($urandom());
         step();
         if (mode_m == 3) check("R5");
         else if (mode_m == 1) check("R3");
         else check("R9");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule